// File: doc/BRIEF.md
# Packetized OTP Read Controller

This block reads a one-time-programmable word array whose contents form a chain of variable-length packets. A packet is a single header word followed by its payload. The header's size field says how long the packet is, so the only way to find a given packet is to start at word 0 and step from header to header. Software does not fetch single words. It writes a word address into the mode register and sets the start bit in the control register. The controller then walks the header chain, one header per cycle, until it reaches the packet whose span covers that address. It copies that packet's header into the header register and its payload into a local buffer.

While the walk and the copy are running, the status register shows a busy flag. Once the flag drops, software reads the header. It then writes 0 to the payload index register and pulls payload words one by one from the data register. If the walk reaches a zero-size header, or runs off the end of the array, the result is an all-zero header and an empty payload. The array is internal storage, filled through a separate load port. That port accepts writes only while the controller is idle.

Top module: `otp_pkt_reader`

## Requirements
- R1: Register offsets are control 0x00, mode 0x04, payload index 0x08, status 0x0C, header 0x20 and data 0x24. The mode register keeps the requested word address in bits 31:16 and reads those bits back with bits 15:0 as zero. The control register always reads zero.
- R2: Writing 1 to bit 6 of the control register while idle starts a read. From the following cycle the status register reads 0x40 until the packet has been copied. After that it reads 0x00. No other status bit is ever set, and after reset status reads 0 and the header register reads 0.
- R3: A requested address in the range from a packet's header position up to, but not including, the next header position selects that packet. The header register then returns the packet's header word unchanged.
- R4: The payload size sits in header bits 15:8. The next header is at the current header position plus size plus 2.
- R5: Writing 0 to the payload index register rewinds the payload pointer. Each following read of the data register returns the next payload word in array order, size plus 1 words in all.
- R6: A data register read made after the last payload word returns 0 and leaves the pointer where it is.
- R7: When the walk meets a header with size field 0 before reaching the address, the header register reads 0 and every data read returns 0.
- R8: The array holds 2816 words. A walk whose next header position is at or past word 2816 gives a zero header and an empty payload. Payload words of a selected packet that lie past word 2815 read as 0.
- R9: A start request made while busy is ignored. The packet chosen by the accepted request is the one that ends up loaded.
- R10: A load-port write (enable, word address, data) made while a read is in progress leaves the array unchanged. Load-port writes made while idle store the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| ld_en | input | 1 | Array load strobe |
| ld_addr | input | 12 | Array word address to load |
| ld_data | input | 32 | Array word to load |

## Verification
The assertions assume that a register access lasts exactly one cycle, so each data-register read strobe counts as one pop. They also assume that a read and a write of the index register never occur in the same cycle. The bench meets this by driving every access for one cycle from the falling edge, with an idle cycle between accesses. The pointer-advance property also assumes that software does not read the data register while busy. The bench only reads payload after polling status down to 0.

// File: rtl/otp_pkt_pkg.sv
`timescale 1ns/1ps
package otp_pkt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned POS_W   = ADDR_W + 1;
  localparam int unsigned SZ_W    = 8;
  localparam int unsigned SZ_LSB  = 8;
  localparam int unsigned IDX_W   = SZ_W + 1;
  localparam int unsigned NBUF    = 1 << SZ_W;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_COPY} walk_st_e;

  function automatic logic [SZ_W-1:0] hdr_size(input logic [WORD_W-1:0] h);
    return h[SZ_LSB +: SZ_W];
  endfunction

  function automatic logic [POS_W-1:0] next_hdr(input logic [POS_W-1:0] pos,
                                                input logic [SZ_W-1:0]  sz);
    return pos + POS_W'(sz) + POS_W'(2);
  endfunction

  function automatic logic in_packet(input logic [ADDR_W-1:0] a,
                                     input logic [POS_W-1:0]  pos,
                                     input logic [SZ_W-1:0]   sz);
    return ({1'b0, a} >= pos) && ({1'b0, a} < next_hdr(pos, sz));
  endfunction
endpackage

// File: rtl/otp_word_array.sv
`timescale 1ns/1ps
module otp_word_array
  import otp_pkt_pkg::*;
#(
  parameter int unsigned DEPTH = 2816,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [POS_W-1:0]  rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic              rd_in_range;

  assign rd_in_range = rd_addr < POS_W'(DEPTH);
  assign rd_data     = rd_in_range ? mem[rd_addr[AW-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < AW'(DEPTH))) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/otp_chain_walker.sv
`timescale 1ns/1ps
module otp_chain_walker
  import otp_pkt_pkg::*;
#(
  parameter int unsigned DEPTH = 2816
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [POS_W-1:0]  arr_addr,
  input  logic [WORD_W-1:0] arr_data,
  output logic              busy,
  output logic [WORD_W-1:0] hdr_q,
  output logic [IDX_W-1:0]  plen_q,
  output logic              buf_we,
  output logic [SZ_W-1:0]   buf_widx,
  output logic [WORD_W-1:0] buf_wdata,
  output logic              walk_hit,
  output logic              walk_end,
  output logic              copy_done
);
  walk_st_e          st_q;
  logic [POS_W-1:0]  pos_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SZ_W-1:0]   cnt_q;
  logic [SZ_W-1:0]   sz_q;
  logic [SZ_W-1:0]   cur_sz;
  logic              past_array;

  assign cur_sz     = hdr_size(arr_data);
  assign past_array = pos_q >= POS_W'(DEPTH);
  assign walk_end   = (st_q == ST_SCAN) && (past_array || (cur_sz == '0));
  assign walk_hit   = (st_q == ST_SCAN) && !walk_end && in_packet(addr_q, pos_q, cur_sz);
  assign copy_done  = (st_q == ST_COPY) && (cnt_q == sz_q);
  assign busy       = st_q != ST_IDLE;

  assign arr_addr   = (st_q == ST_COPY) ? pos_q + POS_W'(1) + POS_W'(cnt_q) : pos_q;
  assign buf_we     = st_q == ST_COPY;
  assign buf_widx   = cnt_q;
  assign buf_wdata  = arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pos_q  <= '0;
      addr_q <= '0;
      cnt_q  <= '0;
      sz_q   <= '0;
      hdr_q  <= '0;
      plen_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          pos_q  <= '0;
          addr_q <= req_addr;
          st_q   <= ST_SCAN;
        end
        ST_SCAN: begin
          if (walk_end) begin
            hdr_q  <= '0;
            plen_q <= '0;
            st_q   <= ST_IDLE;
          end else if (walk_hit) begin
            hdr_q  <= arr_data;
            plen_q <= IDX_W'(cur_sz) + IDX_W'(1);
            sz_q   <= cur_sz;
            cnt_q  <= '0;
            st_q   <= ST_COPY;
          end else begin
            pos_q  <= next_hdr(pos_q, cur_sz);
          end
        end
        ST_COPY: begin
          cnt_q <= cnt_q + SZ_W'(1);
          if (copy_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_payload_buf.sv
`timescale 1ns/1ps
module otp_payload_buf
  import otp_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SZ_W-1:0]   wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  plen,
  input  logic              rewind,
  input  logic [IDX_W-1:0]  rewind_val,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_word,
  output logic [IDX_W-1:0]  idx_q
);
  logic [WORD_W-1:0] buf_mem [NBUF];
  logic              has_word;

  assign has_word = idx_q < plen;
  assign rd_word  = has_word ? buf_mem[idx_q[SZ_W-1:0]] : '0;

  always_ff @(posedge clk) begin
    if (wr_en) buf_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 idx_q <= '0;
    else if (rewind)            idx_q <= rewind_val;
    else if (pop && has_word)   idx_q <= idx_q + IDX_W'(1);
  end
endmodule

// File: rtl/otp_pkt_reader.sv
`timescale 1ns/1ps
module otp_pkt_reader
  import otp_pkt_pkg::*;
#(
  parameter int unsigned DEPTH = 2816,
  localparam int unsigned LD_AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ld_en,
  input  logic [LD_AW-1:0]  ld_addr,
  input  logic [31:0]       ld_data
);
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h04;
  localparam logic [7:0] OFS_IDX  = 8'h08;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_HDR  = 8'h20;
  localparam logic [7:0] OFS_DATA = 8'h24;
  localparam int unsigned GO_BIT  = 6;

  logic              wr_acc, rd_acc;
  logic              start_acc, rewind, pop, mem_we, busy;
  logic [ADDR_W-1:0] mode_q;
  logic [POS_W-1:0]  arr_addr;
  logic [WORD_W-1:0] arr_data, hdr_q, rd_word, buf_wdata;
  logic [IDX_W-1:0]  plen_q, idx_q;
  logic              buf_we, walk_hit, walk_end, copy_done;
  logic [SZ_W-1:0]   buf_widx;

  assign wr_acc    = reg_en && reg_we;
  assign rd_acc    = reg_en && !reg_we;
  assign start_acc = wr_acc && (reg_addr == OFS_CTRL) && reg_wdata[GO_BIT] && !busy;
  assign rewind    = wr_acc && (reg_addr == OFS_IDX);
  assign pop       = rd_acc && (reg_addr == OFS_DATA);
  assign mem_we    = ld_en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  mode_q <= '0;
    else if (wr_acc && (reg_addr == OFS_MODE))   mode_q <= reg_wdata[31:16];
  end

  always_comb begin
    unique case (reg_addr)
      OFS_MODE: reg_rdata = {mode_q, 16'h0000};
      OFS_STAT: reg_rdata = 32'(busy) << GO_BIT;
      OFS_HDR:  reg_rdata = hdr_q;
      OFS_DATA: reg_rdata = rd_word;
      default:  reg_rdata = '0;
    endcase
  end

  otp_word_array #(.DEPTH(DEPTH)) u_array (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (arr_addr),
    .rd_data (arr_data)
  );

  otp_chain_walker #(.DEPTH(DEPTH)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_acc),
    .req_addr  (mode_q),
    .arr_addr  (arr_addr),
    .arr_data  (arr_data),
    .busy      (busy),
    .hdr_q     (hdr_q),
    .plen_q    (plen_q),
    .buf_we    (buf_we),
    .buf_widx  (buf_widx),
    .buf_wdata (buf_wdata),
    .walk_hit  (walk_hit),
    .walk_end  (walk_end),
    .copy_done (copy_done)
  );

  otp_payload_buf u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (buf_we),
    .wr_idx     (buf_widx),
    .wr_data    (buf_wdata),
    .plen       (plen_q),
    .rewind     (rewind),
    .rewind_val (reg_wdata[IDX_W-1:0]),
    .pop        (pop),
    .rd_word    (rd_word),
    .idx_q      (idx_q)
  );
endmodule

// File: rtl/otp_pkt_reader_chk.sv
`timescale 1ns/1ps
module otp_pkt_reader_chk
  import otp_pkt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic              busy,
  input logic              walk_hit,
  input logic              walk_end,
  input logic              copy_done,
  input logic              pop,
  input logic [WORD_W-1:0] hdr_q,
  input logic [IDX_W-1:0]  plen_q,
  input logic [IDX_W-1:0]  idx_q
);
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);

  p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !walk_end && !copy_done) |=> busy);

  p_hit_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_hit |=> (plen_q != '0) && busy);

  p_end_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> (hdr_q == '0) && (plen_q == '0) && !busy);

  p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !busy && (idx_q < plen_q)) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

  p_pop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && (idx_q >= plen_q)) |=> $stable(idx_q));
endmodule

bind otp_pkt_reader otp_pkt_reader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_acc (start_acc),
  .busy      (busy),
  .walk_hit  (walk_hit),
  .walk_end  (walk_end),
  .copy_done (copy_done),
  .pop       (pop),
  .hdr_q     (hdr_q),
  .plen_q    (plen_q),
  .idx_q     (idx_q)
);

// File: tb/tb_otp_pkt_reader.sv
`timescale 1ns/1ps
module tb_otp_pkt_reader;
  localparam int DEPTH = 2816;
  localparam logic [7:0] A_CTRL = 8'h00, A_MODE = 8'h04, A_IDX = 8'h08,
                         A_STAT = 8'h0C, A_HDR = 8'h20, A_DATA = 8'h24;

  logic        clk = 0, rst_n = 0;
  logic        reg_en = 0, reg_we = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        ld_en = 0;
  logic [11:0] ld_addr = 0;
  logic [31:0] ld_data = 0;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] mdl [DEPTH];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  otp_pkt_reader dut (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_en = 0; reg_we = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_en = 0;
  endtask

  task automatic load(input int a, input logic [31:0] d, input bit mirror);
    @(negedge clk); ld_en = 1; ld_addr = 12'(a); ld_data = d;
    @(negedge clk); ld_en = 0;
    if (mirror) mdl[a] = d;
  endtask

  task automatic start_read(input int a);
    bus_wr(A_MODE, 32'(a) << 16);
    bus_wr(A_CTRL, 32'h40);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      bus_rd(A_STAT, s);
      if (s == 32'h0) return;
    end
    chk("R2 busy never cleared", 32'h40, 32'h0);
  endtask

  // Driver side: independent chain walk over the bench's own copy of the array.
  task automatic expect_packet(input int a, input string tag);
    int pos = 0, sz, base = 0, n = 0;
    logic [31:0] h = 0;
    forever begin
      if (pos >= DEPTH) begin h = 0; n = 0; break; end
      h = mdl[pos]; sz = int'(h[15:8]);
      if (sz == 0) begin h = 0; n = 0; break; end
      if (a < pos + sz + 2) begin base = pos; n = sz + 1; break; end
      pos = pos + sz + 2;
    end
    exp_q.push_back(h); tag_q.push_back({tag, " header"});
    for (int i = 0; i < n; i++) begin
      exp_q.push_back((base + 1 + i < DEPTH) ? mdl[base + 1 + i] : 32'h0);
      tag_q.push_back({tag, " payload"});
    end
    exp_q.push_back(32'h0); tag_q.push_back({"R6 past-end ", tag});
    exp_q.push_back(32'h0); tag_q.push_back({"R6 past-end repeat ", tag});
  endtask

  // Monitor side: pull header then payload from the design and compare.
  task automatic drain();
    logic [31:0] d;
    bus_rd(A_HDR, d);
    chk(tag_q.pop_front(), d, exp_q.pop_front());
    bus_wr(A_IDX, 32'h0);
    while (exp_q.size() > 0) begin
      bus_rd(A_DATA, d);
      chk(tag_q.pop_front(), d, exp_q.pop_front());
    end
  endtask

  task automatic read_check(input int a, input string tag);
    start_read(a);
    wait_idle();
    expect_packet(a, tag);
    drain();
  endtask

  function automatic logic [31:0] mk_hdr(input int id, input int sz);
    return {8'h5A, 8'(id), 8'(sz), 8'h3C};
  endfunction

  initial begin
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    bus_rd(A_STAT, d); chk("R2 reset status", d, 32'h0);
    bus_rd(A_HDR, d);  chk("R2 reset header", d, 32'h0);

    bus_wr(A_MODE, 32'hABCD_1234);
    bus_rd(A_MODE, d); chk("R1 mode readback", d, 32'hABCD_0000);
    bus_wr(A_CTRL, 32'h0000_0001);
    bus_rd(A_CTRL, d); chk("R1 control reads zero", d, 32'h0);

    // R4 chain: P0 @0 size 3, P1 @5 size 1, P2 @8 size 2, terminator @12
    load(0, mk_hdr(0, 3), 1);
    for (int i = 1; i <= 4; i++) load(i, 32'hD000_0000 | 32'(i), 1);
    load(5, mk_hdr(1, 1), 1);
    for (int i = 6; i <= 7; i++) load(i, 32'hD000_0000 | 32'(i), 1);
    load(8, mk_hdr(2, 2), 1);
    for (int i = 9; i <= 11; i++) load(i, 32'hD000_0000 | 32'(i), 1);
    load(12, 32'h0000_00FF, 1);

    start_read(11);
    bus_rd(A_STAT, d); chk("R2 status busy", d, 32'h40);
    wait_idle();
    bus_rd(A_STAT, d); chk("R2 status idle", d, 32'h0);
    expect_packet(11, "R3 R4 addr 11"); drain();

    read_check(0, "R3 addr 0");
    read_check(4, "R3 addr 4 last word of P0");
    read_check(5, "R4 addr 5 second header");
    read_check(7, "R3 addr 7");
    read_check(8, "R5 addr 8");

    // R5 rewind in the middle of the payload
    bus_wr(A_IDX, 32'h0);
    bus_rd(A_DATA, d); chk("R5 first word", d, mdl[1 + 8]);
    bus_rd(A_DATA, d); chk("R5 second word", d, mdl[2 + 8]);
    bus_wr(A_IDX, 32'h0);
    bus_rd(A_DATA, d); chk("R5 after rewind", d, mdl[1 + 8]);

    read_check(12, "R7 addr on zero header");
    read_check(40, "R7 addr past terminator");

    // R9: second start while busy is ignored
    start_read(8);
    bus_wr(A_MODE, 32'h0);
    bus_wr(A_CTRL, 32'h40);
    wait_idle();
    expect_packet(8, "R9 ignored restart"); drain();

    // R10: load while busy has no effect
    start_read(11);
    load(6, 32'hBAD0_BAD0, 0);
    wait_idle();
    read_check(5, "R10 blocked load");

    // R8: fill the whole array with size-255 packets
    for (int k = 0; k < 11; k++) begin
      int p = k * 257;
      load(p, mk_hdr(k, 255), 1);
      for (int i = 1; i < 257; i++)
        if (p + i < DEPTH) load(p + i, 32'hE000_0000 | 32'(p + i), 1);
    end
    read_check(2569, "R8 addr 2569 packet 9");
    read_check(2570, "R8 addr 2570 packet 10");
    read_check(2815, "R8 clipped packet at array end");
    read_check(3000, "R8 walk past array end");

    summary();
  end
endmodule